// File: doc/BRIEF.md
# DC input fault detector

This block watches the decoded left and right audio sample streams for a sustained DC level, the signature of a stuck source that would heat a speaker coil. Each channel keeps a run of accepted samples whose magnitude sits at or above a programmable level and whose sign stays the same. When a run grows longer than a programmable number of samples, that channel reports a fault. A combined fault is the OR of both channels.

A run ends, and the channel fault drops by itself, when a sample arrives below the level or with the opposite sign. Sleep clears both channels at once. Samples arrive on a valid/ready interface. The block takes one stereo pair per cycle whenever ready is high. Ready is low only while sleep is asserted: the block applies no other back-pressure, and the sender holds a pair until it is taken. The level and the limit are plain static inputs. Change the limit only while sleep is held, so that no run is in progress when it moves.

Top module: `dc_fault_detect`

## Requirements
- R1: After reset, `fault_left`, `fault_right` and `fault_any` are low and every run count is zero.
- R2: The magnitude of a two's-complement sample is its absolute value. The most negative code saturates to the largest positive value. A sample counts as at level when its magnitude, compared unsigned, is greater than or equal to `level`.
- R3: A channel fault rises one clock after the accepted sample that makes the run of at-level, same-sign samples longer than `limit`.
- R4: An at-level sample whose sign bit differs from that of the current run restarts the run at length one and clears the fault.
- R5: An accepted sample below the level ends the run and clears that channel's fault.
- R6: Cycles in which no sample is accepted change neither the faults nor the run counts.
- R7: While `sleep` is high, `in_ready` is low, samples are ignored, and the faults and counts are cleared one clock later.
- R8: The channels are independent, and `fault_any` is high exactly when either channel fault is high.
- R9: With `limit` equal to zero, the first at-level sample of a run raises the fault.
- R10: The run count saturates at `limit`, so a run of any length past the limit keeps the fault high without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A stereo sample pair is presented |
| in_ready | output | 1 | A pair is taken this cycle when valid; low only during sleep |
| in_left | input | SAMPLE_W | Left sample, two's complement |
| in_right | input | SAMPLE_W | Right sample, two's complement |
| level | input | SAMPLE_W-1 | Detection level as an unsigned magnitude |
| limit | input | CNT_W | Longest run of samples allowed without a fault |
| sleep | input | 1 | Clears both channels and blocks input |
| fault_left | output | 1 | Left channel DC fault |
| fault_right | output | 1 | Right channel DC fault |
| fault_any | output | 1 | OR of the two channel faults |

## Verification
The hardest states to reach are a run that has already passed its limit and then meets a sign flip, and the boundary magnitudes around the most negative code. A real limit of tens of thousands of samples would make these states slow to reach. The stimulus therefore programs small limits during sleep and streams a valid pair on every cycle, which builds long saturated runs within a few hundred cycles. Against those runs it applies sign flips, exact-threshold magnitudes, the most negative code with the level at full scale, and a zero limit. A random phase with a narrow set of values produces many short runs that break in both ways.

// File: rtl/dcfd_pkg.sv
package dcfd_pkg;
  typedef enum logic [1:0] {
    EV_HOLD  = 2'd0,
    EV_BREAK = 2'd1,
    EV_START = 2'd2,
    EV_CONT  = 2'd3
  } run_event_e;
endpackage

// File: rtl/dcfd_level_detect.sv
module dcfd_level_detect #(
  parameter int SAMPLE_W = 24
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SAMPLE_W-2:0] level,
  output logic                at_level,
  output logic                negative
);
  localparam int MAG_W = SAMPLE_W - 1;
  localparam logic [MAG_W-1:0] MAG_ONE = MAG_W'(1);

  logic             most_neg;
  logic [MAG_W-1:0] magnitude;

  assign negative = sample[SAMPLE_W-1];
  assign most_neg = negative && ~|sample[MAG_W-1:0];

  always_comb begin
    if (!negative)      magnitude = sample[MAG_W-1:0];
    else if (most_neg)  magnitude = '1;
    else                magnitude = ~sample[MAG_W-1:0] + MAG_ONE;
  end

  assign at_level = (magnitude >= level);
endmodule

// File: rtl/dcfd_run_tracker.sv
module dcfd_run_tracker
  import dcfd_pkg::*;
#(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             accept,
  input  logic             at_level,
  input  logic             negative,
  input  logic [CNT_W-1:0] limit,
  output logic             fault
);
  localparam int RUN_W = CNT_W + 1;

  run_event_e       ev;
  logic [CNT_W-1:0] count_q;
  logic             armed_q;
  logic             neg_q;
  logic             fault_q;
  logic [RUN_W-1:0] run_next;
  logic             over;

  always_comb begin
    if (!accept)                           ev = EV_HOLD;
    else if (!at_level)                    ev = EV_BREAK;
    else if (!armed_q || negative != neg_q) ev = EV_START;
    else                                   ev = EV_CONT;
  end

  always_comb begin
    if (ev == EV_START) run_next = RUN_W'(1);
    else                run_next = {1'b0, count_q} + RUN_W'(1);
  end

  assign over = (run_next > {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      armed_q <= 1'b0;
      neg_q   <= 1'b0;
      fault_q <= 1'b0;
    end else if (clear) begin
      count_q <= '0;
      armed_q <= 1'b0;
      neg_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      case (ev)
        EV_BREAK: begin
          count_q <= '0;
          armed_q <= 1'b0;
          fault_q <= 1'b0;
        end
        EV_START, EV_CONT: begin
          count_q <= over ? limit : run_next[CNT_W-1:0];
          fault_q <= over;
          armed_q <= 1'b1;
          neg_q   <= negative;
        end
        default: ;
      endcase
    end
  end

  assign fault = fault_q;

  assert_sleep_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!fault_q && count_q == '0));

  assert_below_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && accept && !at_level) |=> !fault_q);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !accept) |=> ($stable(fault_q) && $stable(count_q)));

  assert_flip_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && accept && at_level && armed_q && negative != neg_q) |=> (count_q <= CNT_W'(1)));

  assert_rise_on_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $past(accept));

  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !clear && accept && at_level && armed_q && negative == neg_q) |=> fault_q);
endmodule

// File: rtl/dcfd_channel.sv
module dcfd_channel #(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                accept,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SAMPLE_W-2:0] level,
  input  logic [CNT_W-1:0]    limit,
  output logic                fault
);
  logic at_level;
  logic negative;

  dcfd_level_detect #(.SAMPLE_W(SAMPLE_W)) u_detect (
    .sample   (sample),
    .level    (level),
    .at_level (at_level),
    .negative (negative)
  );

  dcfd_run_tracker #(.CNT_W(CNT_W)) u_tracker (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .accept   (accept),
    .at_level (at_level),
    .negative (negative),
    .limit    (limit),
    .fault    (fault)
  );
endmodule

// File: rtl/dc_fault_detect.sv
module dc_fault_detect #(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic [SAMPLE_W-2:0] level,
  input  logic [CNT_W-1:0]    limit,
  input  logic                sleep,
  output logic                fault_left,
  output logic                fault_right,
  output logic                fault_any
);
  localparam int NUM_CH = 2;

  logic [SAMPLE_W-1:0] samples [NUM_CH];
  logic [NUM_CH-1:0]   faults;
  logic                accept;

  assign in_ready   = !sleep;
  assign accept     = in_valid && in_ready;
  assign samples[0] = in_left;
  assign samples[1] = in_right;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    dcfd_channel #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (sleep),
      .accept (accept),
      .sample (samples[ch]),
      .level  (level),
      .limit  (limit),
      .fault  (faults[ch])
    );
  end

  assign fault_left  = faults[0];
  assign fault_right = faults[1];
  assign fault_any   = |faults;

  assert_sleep_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !fault_any);
endmodule

// File: tb/dc_fault_detect_tb.sv
module dc_fault_detect_tb;
  localparam int W  = 24;
  localparam int CW = 18;
  localparam longint MAXPOS = 64'd8388607;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_left = '0;
  logic [W-1:0] in_right = '0;
  logic [W-2:0] level = 23'd1056000;
  logic [CW-1:0] limit = 18'd5;
  logic sleep = 1'b0;
  logic fault_left, fault_right, fault_any;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  int run_len [2];
  bit armed [2];
  bit lastneg [2];
  bit mfault [2];

  always #4 clk = ~clk;

  dc_fault_detect #(.SAMPLE_W(W), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .level(level), .limit(limit),
    .sleep(sleep), .fault_left(fault_left), .fault_right(fault_right),
    .fault_any(fault_any)
  );

  // behavioural reference: unbounded run length per channel
  always @(posedge clk) begin
    if (!rst_n || sleep) begin
      for (int c = 0; c < 2; c++) begin
        run_len[c] = 0; armed[c] = 0; lastneg[c] = 0; mfault[c] = 0;
      end
    end else if (in_valid) begin
      for (int c = 0; c < 2; c++) begin
        longint s, mag;
        bit neg;
        s = (c == 0) ? longint'($signed(in_left)) : longint'($signed(in_right));
        neg = (s < 0);
        mag = neg ? -s : s;
        if (mag > MAXPOS) mag = MAXPOS;
        if (mag < longint'(level)) begin
          run_len[c] = 0; armed[c] = 0; mfault[c] = 0;
        end else begin
          if (!armed[c] || neg != lastneg[c]) run_len[c] = 1;
          else run_len[c] = run_len[c] + 1;
          armed[c] = 1; lastneg[c] = neg;
          mfault[c] = (run_len[c] > int'(limit));
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (fault_left !== mfault[0] || fault_right !== mfault[1] ||
          fault_any !== (mfault[0] | mfault[1]) || in_ready !== !sleep) begin
        errors++;
        $display("FAIL %s: model compare L/R/any/ready actual %0b%0b%0b%0b expected %0b%0b%0b%0b",
                 cur_req, fault_left, fault_right, fault_any, in_ready,
                 mfault[0], mfault[1], mfault[0] | mfault[1], !sleep);
      end
    end
  end

  task automatic put(input bit v, input logic [W-1:0] l, input logic [W-1:0] r);
    @(posedge clk); #2;
    in_valid = v; in_left = l; in_right = r;
  endtask

  task automatic check(input string req, input bit el, input bit er);
    put(1'b0, '0, '0);
    @(negedge clk);
    checks++;
    if (fault_left !== el || fault_right !== er || fault_any !== (el | er)) begin
      errors++;
      $display("FAIL %s: L/R/any actual %0b%0b%0b expected %0b%0b%0b",
               req, fault_left, fault_right, fault_any, el, er, el | er);
    end
  endtask

  task automatic sleep_set(input logic [W-2:0] lv, input logic [CW-1:0] lim);
    @(posedge clk); #2; sleep = 1'b1; in_valid = 1'b1; in_left = 24'h7FFFFF; in_right = 24'h7FFFFF;
    @(posedge clk); #2; level = lv; limit = lim;
    @(negedge clk);
    checks++;
    if (in_ready !== 1'b0 || fault_any !== 1'b0) begin
      errors++;
      $display("FAIL R7: ready/any during sleep actual %0b%0b expected 00", in_ready, fault_any);
    end
    @(posedge clk); #2; sleep = 1'b0; in_valid = 1'b0;
  endtask

  localparam logic [W-1:0] BIGP = 24'd2000000;
  localparam logic [W-1:0] BIGN = -24'sd2000000;

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    cur_req = "R1";
    check("R1", 0, 0);

    cur_req = "R3";
    repeat (5) put(1, BIGP, 0);
    check("R3", 0, 0);
    put(1, BIGP, 0);
    check("R3", 1, 0);
    cur_req = "R6";
    repeat (6) put(0, 24'h800000, 24'h800000);
    check("R6", 1, 0);
    cur_req = "R10";
    repeat (200) put(1, BIGP, 0);
    check("R10", 1, 0);

    cur_req = "R5";
    put(1, 24'd1055999, 0);
    check("R5", 0, 0);
    repeat (3) put(1, 24'd1056000, 0);
    put(1, -24'sd1056000, 0);
    check("R2", 0, 0);

    cur_req = "R4";
    repeat (8) put(1, BIGP, 0);
    check("R4", 1, 0);
    put(1, BIGN, 0);
    check("R4", 0, 0);
    repeat (4) put(1, BIGN, 0);
    check("R4", 0, 0);
    put(1, BIGN, 0);
    check("R4", 1, 0);

    cur_req = "R7";
    sleep_set(23'h7FFFFF, 18'd0);
    check("R7", 0, 0);

    cur_req = "R9";
    put(1, 24'h800000, 0);
    check("R2", 1, 0);
    put(1, 24'd8388606, 0);
    check("R9", 0, 0);
    put(1, 24'h800001, 0);
    check("R9", 1, 0);

    cur_req = "R8";
    sleep_set(23'd1056000, 18'd3);
    for (int i = 0; i < 4; i++) put(1, (i % 2) ? BIGN : BIGP, BIGP);
    check("R8", 0, 1);

    cur_req = "R7";
    repeat (6) put(1, BIGP, BIGP);
    check("R7", 1, 1);
    sleep_set(23'd1056000, 18'd3);
    repeat (3) put(1, BIGP, BIGP);
    check("R7", 0, 0);
    put(1, BIGP, BIGP);
    check("R7", 1, 1);

    cur_req = "R3";
    sleep_set(23'd1000, 18'd4);
    for (int i = 0; i < 1500; i++) begin
      logic [W-1:0] pick [4];
      pick[0] = 24'd5000; pick[1] = -24'sd5000; pick[2] = 24'd999; pick[3] = 24'h800000;
      put(($urandom % 5) != 0, pick[($urandom % 8) < 6 ? 0 : ($urandom % 4)],
          pick[($urandom % 8) < 5 ? 1 : ($urandom % 4)]);
    end
    put(0, 0, 0);
    repeat (2) @(posedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    done = 1'b1;
    errors++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule